// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by fetching a mapping from a two-level page table held in memory. A miss request carries a 32-bit virtual address and the root pointer of the table tree. The upper ten address bits select a directory entry, the next ten select an entry inside the second-level table that the directory entry points to, and the low twelve bits are the offset within a 4 KB page. They pass through untranslated.

The walker issues the directory read first. It issues the second read only when the directory entry is valid. When both entries are valid, it returns the final entry for loading into the translation buffer, together with the translated physical address. When either entry is invalid, it returns a fault that names the level that failed. One walk is in flight at a time, and new misses are held off until the response has been given. Memory reads use a request/ready handshake, and the data comes back with a read-valid strobe after any number of cycles.

Top module: `pgwalk2`

## Requirements
- R1: After reset, `miss_ready` is 1, and both `mem_req_valid` and `resp_valid` are 0.
- R2: A miss is accepted on a clock edge where `miss_valid` and `miss_ready` are both 1. From then until the response cycle has ended, `miss_ready` stays 0, and any other miss presented in that window is ignored.
- R3: The first memory read of a walk uses the address `root_ptr + 4*va[31:22]`, with the root pointer taken at acceptance.
- R4: If bit 0 of the directory entry is 0, the walk ends with `resp_fault`=1 and `resp_level`=0, and no second read is issued.
- R5: The second read uses the address `{dir_entry[31:12], va[21:12], 2'b00}`.
- R6: If bit 0 of the second-level entry is 0, the walk ends with `resp_fault`=1 and `resp_level`=1.
- R7: If bit 0 of the second-level entry is 1, the response has `resp_fault`=0, `resp_level`=1, `resp_pte` equal to that entry, and `resp_paddr`={entry[31:12], va[11:0]}.
- R8: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request and its address hold steady into the next cycle.
- R9: `resp_valid` is a one-cycle pulse. `miss_ready` returns to 1 in the cycle after it.
- R10: Read data is taken only in a cycle where `mem_rsp_valid` is 1 after an accepted request, whatever the latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Walker idle, can take a miss |
| miss_va | input | 32 | Virtual address that missed |
| root_ptr | input | 32 | Byte address of the directory |
| resp_valid | output | 1 | Response pulse |
| resp_fault | output | 1 | Walk found an invalid entry |
| resp_level | output | 1 | 0 for directory, 1 for second level |
| resp_pte | output | 32 | Last entry read |
| resp_paddr | output | 32 | Translated physical address |
| mem_req_valid | output | 1 | Read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Read byte address |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Read data |

## Verification
The properties assume that memory raises `mem_rsp_valid` exactly once for each accepted read, and never while no read is outstanding. The bench's memory model honours this: it records each accepted address and returns one word after a random delay of zero to three cycles. It also toggles `mem_req_ready` at random, so that held requests occur. Miss requests are driven only between clock edges, and some are held high through a walk to probe back-pressure.

// File: rtl/pgwalk2.sv
module pgwalk2 #(
  parameter int AW    = 32,
  parameter int DIR_W = 10,
  parameter int TBL_W = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          miss_valid,
  output logic          miss_ready,
  input  logic [AW-1:0] miss_va,
  input  logic [AW-1:0] root_ptr,
  output logic          resp_valid,
  output logic          resp_fault,
  output logic          resp_level,
  output logic [AW-1:0] resp_pte,
  output logic [AW-1:0] resp_paddr,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data
);
  localparam int OFF_W = AW - DIR_W - TBL_W;
  localparam int TI_LO = OFF_W;
  localparam int DI_LO = OFF_W + TBL_W;

  typedef enum logic [2:0] {S_IDLE, S_DREQ, S_DWAIT, S_TREQ, S_TWAIT, S_DONE} st_t;

  st_t           st;
  logic [AW-1:0] va_q, root_q, ent_q;
  logic          flt_q, lvl_q;

  logic [AW-1:0] dir_addr, tbl_addr;
  assign dir_addr = root_q + AW'({va_q[AW-1:DI_LO], 2'b00});
  assign tbl_addr = {ent_q[AW-1:OFF_W], va_q[DI_LO-1:TI_LO], 2'b00};

  assign miss_ready    = (st == S_IDLE);
  assign mem_req_valid = (st == S_DREQ) || (st == S_TREQ);
  assign mem_req_addr  = (st == S_TREQ) ? tbl_addr : dir_addr;
  assign resp_valid    = (st == S_DONE);
  assign resp_fault    = flt_q;
  assign resp_level    = lvl_q;
  assign resp_pte      = ent_q;
  assign resp_paddr    = {ent_q[AW-1:OFF_W], va_q[OFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      va_q   <= '0;
      root_q <= '0;
      ent_q  <= '0;
      flt_q  <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (miss_valid) begin
          va_q   <= miss_va;
          root_q <= root_ptr;
          st     <= S_DREQ;
        end
        S_DREQ: if (mem_req_ready) st <= S_DWAIT;
        S_DWAIT: if (mem_rsp_valid) begin
          ent_q <= mem_rsp_data;
          if (mem_rsp_data[0]) st <= S_TREQ;
          else begin
            flt_q <= 1'b1;
            lvl_q <= 1'b0;
            st    <= S_DONE;
          end
        end
        S_TREQ: if (mem_req_ready) st <= S_TWAIT;
        S_TWAIT: if (mem_rsp_valid) begin
          ent_q <= mem_rsp_data;
          flt_q <= ~mem_rsp_data[0];
          lvl_q <= 1'b1;
          st    <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module pgwalk2_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          miss_ready,
  input logic          resp_valid,
  input logic          resp_fault,
  input logic          resp_level,
  input logic [AW-1:0] resp_pte,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr
);
  // R2
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || resp_valid) |-> !miss_ready);
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  // R9
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> (!resp_valid && miss_ready));
  // R7
  ok_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_fault) |-> (resp_pte[0] && resp_level));
  // R4
  fault_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> !resp_pte[0]);
endmodule

bind pgwalk2 pgwalk2_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_ready(miss_ready), .resp_valid(resp_valid),
  .resp_fault(resp_fault), .resp_level(resp_level), .resp_pte(resp_pte),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr));

// File: tb/pgwalk2_test.sv
module pgwalk2_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [31:0] miss_va = '0;
  logic [31:0] root_ptr = '0;
  logic        resp_valid, resp_fault, resp_level;
  logic [31:0] resp_pte, resp_paddr;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pgwalk2 uut (.*);

  logic [31:0] mem [logic [31:0]];
  logic [31:0] exp_addr [$];
  bit exp_ready = 1'b1;
  bit in_reset = 1'b1;

  function automatic logic [31:0] rd(logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    if (a[31:28] == 4'h4) return {a[21:2] ^ 20'hA5C3F, 11'h0, (a[4:2] != 3'b111)};
    return 32'h0;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock reference of the busy window
  always @(negedge clk) begin
    if (!in_reset) begin
      chk(miss_ready == exp_ready, "R2 ready", 32'(miss_ready), 32'(exp_ready));
      if (exp_ready) chk(!mem_req_valid && !resp_valid, "R9 idle quiet",
                         {mem_req_valid, resp_valid}, 0);
      if (miss_valid && miss_ready) exp_ready = 1'b0;
      else if (resp_valid) exp_ready = 1'b1;
    end
  end

  // memory model
  bit          pend = 0, acc = 0, held = 0;
  int          lat = 0;
  logic [31:0] acc_addr = '0, held_addr = '0;
  initial begin
    forever begin
      @(negedge clk);
      if (held) chk(mem_req_valid && mem_req_addr == held_addr, "R8 hold", mem_req_addr, held_addr);
      held = 1'b0;
      acc = 1'b0;
      if (mem_req_valid && !mem_req_ready) begin
        held = 1'b1;
        held_addr = mem_req_addr;
      end
      if (mem_req_valid && mem_req_ready) begin
        acc = 1'b1;
        acc_addr = mem_req_addr;
        if (exp_addr.size() == 0) chk(0, "R4 extra read", mem_req_addr, 0);
        else begin
          automatic logic [31:0] e = exp_addr.pop_front();
          chk(mem_req_addr == e, "R3/R5 address", mem_req_addr, e);
        end
      end
      @(posedge clk); #1;
      mem_rsp_valid = 1'b0;
      if (acc) begin
        pend = 1'b1;
        lat = $urandom % 4;
      end else if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data = rd(acc_addr);
          pend = 1'b0;
        end else lat--;
      end
      if (!mem_rsp_valid) mem_rsp_data = $urandom; // R10 noise while not valid
      mem_req_ready = ($urandom % 3) != 0;
    end
  end

  task automatic walk(logic [31:0] va, logic [31:0] root, bit hold);
    logic [31:0] da, de, ta, te, xp;
    bit xf, xl;
    int n;
    da = root + {20'h0, va[31:22], 2'b00};
    de = rd(da);
    exp_addr.push_back(da);
    if (!de[0]) begin
      xf = 1; xl = 0; xp = de;
    end else begin
      ta = {de[31:12], va[21:12], 2'b00};
      exp_addr.push_back(ta);
      te = rd(ta);
      xf = !te[0]; xl = 1; xp = te;
    end
    @(posedge clk); #1;
    miss_valid = 1'b1; miss_va = va; root_ptr = root;
    do @(negedge clk); while (!miss_ready);
    @(posedge clk); #1;
    if (hold) begin
      miss_va = ~va; root_ptr = ~root;
    end else miss_valid = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!resp_valid && n < 100);
    chk(resp_valid, "R10 response", 32'(resp_valid), 1);
    chk(resp_fault == xf, xf ? (xl ? "R6 fault" : "R4 fault") : "R7 no fault", 32'(resp_fault), 32'(xf));
    chk(resp_level == xl, xl ? "R6 level" : "R4 level", 32'(resp_level), 32'(xl));
    chk(resp_pte == xp, "R7 entry", resp_pte, xp);
    if (!xf) chk(resp_paddr == {xp[31:12], va[11:0]}, "R7 paddr", resp_paddr, {xp[31:12], va[11:0]});
    chk(exp_addr.size() == 0, "R4 read count", exp_addr.size(), 0);
    @(posedge clk); #1;
    miss_valid = 1'b0;
  endtask

  localparam logic [31:0] ROOT0 = 32'h0001_0000;
  localparam logic [31:0] ROOT1 = 32'h0003_0000;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    foreach (exp_addr[i]) exp_addr.delete();
    for (int k = 0; k < 1024; k += 73) mem[ROOT0 + 32'(k * 4)] = {4'h4, 10'(k), 6'h0, 12'h001};
    mem[ROOT0 + 0]        = {4'h4, 10'h000, 6'h0, 12'h001};
    mem[ROOT0 + 12]       = {4'h4, 10'h003, 6'h0, 12'h001};
    mem[ROOT0 + 4092]     = {4'h4, 10'h3FF, 6'h0, 12'h001};
    mem[ROOT0 + 8]        = {20'h40123, 12'h000};
    mem[ROOT1 + 12]       = {4'h4, 10'h155, 6'h3, 12'h801};
    repeat (3) @(posedge clk);
    #1;
    chk(miss_ready && !mem_req_valid && !resp_valid, "R1 reset",
        {miss_ready, mem_req_valid, resp_valid}, 32'h4);
    rst_n = 1'b1;
    in_reset = 1'b0;
    walk({10'd3, 10'd5, 12'hABC}, ROOT0, 0);
    walk({10'd3, 10'd7, 12'h123}, ROOT0, 0);
    walk({10'd7, 10'd5, 12'h000}, ROOT0, 0);
    walk({10'd2, 10'd5, 12'hFFF}, ROOT0, 1);
    walk({10'd1023, 10'd1023, 12'hFFF}, ROOT0, 1);
    walk({10'd0, 10'd0, 12'h000}, ROOT0, 0);
    walk({10'd3, 10'd9, 12'h456}, ROOT1, 1);
    walk({10'd3, 10'd15, 12'h456}, ROOT1, 0);
    for (int i = 0; i < 40; i++) begin
      logic [9:0] d;
      case ($urandom % 5)
        0: d = 10'd0;
        1: d = 10'd3;
        2: d = 10'd146;
        3: d = 10'($urandom);
        default: d = 10'd1023;
      endcase
      walk({d, 10'($urandom), 12'($urandom)}, (i % 4 == 3) ? ROOT1 : ROOT0, i[0]);
    end
    repeat (4) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule